// File: doc/BRIEF.md
# Virtual-Channel Switch Allocator

This block is the switch-allocation stage of a virtual-channel network-on-chip router. Every input port holds several virtual channels (VCs), and the VCs are grouped into virtual networks (vnets). In each cycle the VCs that are ready for switch traversal present a request. Each request carries a target output port, an output VC if one is already held, a tail flag and an enqueue timestamp. The allocator works in two stages. First it picks at most one eligible VC per input port. Then it picks at most one of those winners per output port. Both stages use round-robin. It issues grants in the same cycle as the requests.

The allocator keeps the state of every output VC at every output port: a downstream credit count and a busy/free flag. A VC is eligible only when its output VC has a credit, or, if it holds no output VC, when a free output VC with credit exists in its vnet at the target port. At grant time such a VC is given the lowest-numbered candidate. Vnets marked as ordered enforce oldest-first among the VCs of one input port that target the same output port.

There is no data path through this block, so no valid/ready handshake is used. Back-pressure is carried only by credits. A VC whose output VC has no credit simply does not win. Downstream credits arrive on one return channel per output port. For each granted input VC the block returns upstream a credit indication, flagged as a VC release when the flit closes its packet.

Top module: `sa_switch_alloc`

## Requirements
- R1: After reset every output VC holds CREDITS credits and is free, all round-robin pointers are 0, and with no requests no grant of any kind is issued.
- R2: Request flat index p*NUM_VCS+v belongs to input port p and VC v, and v sits in vnet v/VCS_PER_VNET. Such a request is eligible only when one of two conditions holds. With req_has_ovc=1, output VC req_ovc at req_outport must have a nonzero credit. With req_has_ovc=0, some output VC of the same vnet at req_outport must be free with nonzero credit. An ineligible request is never granted.
- R3: Per input port, the first-stage winner is the first eligible VC found by scanning upward from that port's pointer, wrapping modulo NUM_VCS. The pointer moves to winner+1 (mod NUM_VCS) only in a cycle when that input port is granted, and otherwise holds.
- R4: Per output port, the second-stage winner is the first input port found by scanning upward from that output's pointer, wrapping, among the input ports whose first-stage winner targets the output. The pointer moves to winner+1 (mod NUM_PORTS) only when that output grants.
- R5: Each input port receives at most one grant per cycle, and so does each output port. Every out_grant[o] has exactly one matching in_grant, on the port out_grant_inport[o], whose in_grant_outport equals o.
- R6: A granted VC that holds an output VC reports it on in_grant_ovc with in_grant_new_ovc=0. Otherwise the block assigns the lowest-index free output VC with credit in the VC's vnet (index range vnet*VCS_PER_VNET upward), reports it with in_grant_new_ovc=1, and marks it busy from the next cycle.
- R7: A grant lowers the credit count of the granted output VC by one. A downstream credit (dn_credit_valid) raises the count of output VC dn_credit_vc by one. Both events in one cycle leave the count unchanged.
- R8: A downstream credit with dn_credit_free=1 frees its output VC from the next cycle on.
- R9: in_release[i] is 1 exactly when input port i is granted and the granted request has req_tail=1.
- R10: In a vnet whose bit in ORDERED_VNETS is 1, a requesting VC is blocked if another requesting VC of the same input port and vnet targets the same output port with a strictly smaller timestamp. Equal timestamps block neither VC. In unordered vnets timestamps have no effect.
- R11: Grants are combinational on the current cycle's requests. A request that is not repeated leaves no pending state and yields no grant in later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NUM_PORTS*NUM_VCS | VC requests switch traversal this cycle |
| req_outport | input | NUM_PORTS*NUM_VCS x PW | Target output port per VC |
| req_has_ovc | input | NUM_PORTS*NUM_VCS | VC already holds an output VC |
| req_ovc | input | NUM_PORTS*NUM_VCS x VW | Held output VC |
| req_tail | input | NUM_PORTS*NUM_VCS | Flit is the last of its packet |
| req_time | input | NUM_PORTS*NUM_VCS x TS_W | Enqueue timestamp of the head flit |
| dn_credit_valid | input | NUM_PORTS | Credit returned for an output VC of this output port |
| dn_credit_vc | input | NUM_PORTS x VW | Output VC the credit belongs to |
| dn_credit_free | input | NUM_PORTS | Credit also releases that output VC |
| in_grant | output | NUM_PORTS | Input port granted this cycle |
| in_grant_vc | output | NUM_PORTS x VW | Granted input VC (valid with in_grant) |
| in_grant_outport | output | NUM_PORTS x PW | Output port of the grant (valid with in_grant) |
| in_grant_ovc | output | NUM_PORTS x VW | Output VC used by the grant (valid with in_grant) |
| in_grant_new_ovc | output | NUM_PORTS | Output VC was assigned in this grant |
| in_release | output | NUM_PORTS | Upstream credit carries the VC-release flag |
| out_grant | output | NUM_PORTS | Output port granted this cycle |
| out_grant_inport | output | NUM_PORTS x PW | Input port that won the output |

## Verification
The situation hardest to reach from the ports is a clash between the credit and busy state and the arbitration order. Examples are an output VC whose last credit is used while a second input contends for it, or a release that comes back in the very cycle a new request needs a free VC. Directed phases drive single outputs into credit exhaustion and vnets into having no free VC. A long sweep then mixes random requests and downstream credit returns against an arithmetic model of the counters and pointers. Small timestamps make ties between ordered VCs frequent.

// File: rtl/sa_pkg.sv
package sa_pkg;
  // width of an index into n items, never below one bit
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/sa_rr_arbiter.sv
module sa_rr_arbiter
  import sa_pkg::*;
#(
  parameter int N = 4,
  localparam int IW = idx_w(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          adv,
  output logic          any,
  output logic [IW-1:0] idx
);
  logic [IW-1:0] ptr;

  // first requester at or above the pointer, wrapping
  always_comb begin
    int c;
    any = 1'b0;
    idx = '0;
    for (int k = 0; k < N; k++) begin
      c = int'(ptr) + k;
      if (c >= N) c = c - N;
      if (!any && req[c]) begin
        any = 1'b1;
        idx = IW'(c);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else if (adv) ptr <= (int'(idx) == N - 1) ? '0 : idx + 1'b1;
  end

  AST_ADV_NEEDS_WINNER: assert property (@(posedge clk) disable iff (!rst_n) adv |-> any); // R3
endmodule

// File: rtl/sa_input_stage.sv
module sa_input_stage
  import sa_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int NUM_VNETS = 2,
  parameter int VCS_PER_VNET = 2,
  parameter int TS_W = 8,
  parameter logic [NUM_VNETS-1:0] ORDERED_VNETS = '0,
  localparam int NUM_VCS = NUM_VNETS * VCS_PER_VNET,
  localparam int PW = idx_w(NUM_PORTS),
  localparam int VW = idx_w(NUM_VCS)
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [NUM_VCS-1:0]                     vc_req,
  input  logic [NUM_VCS-1:0][PW-1:0]             vc_outport,
  input  logic [NUM_VCS-1:0]                     vc_has_ovc,
  input  logic [NUM_VCS-1:0][VW-1:0]             vc_ovc,
  input  logic [NUM_VCS-1:0][TS_W-1:0]           vc_time,
  input  logic [NUM_PORTS-1:0][NUM_VCS-1:0]      ovc_credit_ok,
  input  logic [NUM_PORTS-1:0][NUM_VCS-1:0]      ovc_free,
  input  logic                                   adv,
  output logic                                   win_any,
  output logic [VW-1:0]                          win_vc
);
  logic [NUM_VCS-1:0] elig;

  for (genvar gv = 0; gv < NUM_VCS; gv++) begin : g_vc
    localparam int VN   = gv / VCS_PER_VNET;
    localparam int BASE = VN * VCS_PER_VNET;
    logic el;

    always_comb begin
      int op;
      logic held_ok, free_ok, older;
      op      = int'(vc_outport[gv]);
      held_ok = ovc_credit_ok[op][vc_ovc[gv]];
      free_ok = |(ovc_free[op][BASE +: VCS_PER_VNET] & ovc_credit_ok[op][BASE +: VCS_PER_VNET]);
      older   = 1'b0;
      // oldest-first inside an ordered vnet, per target port
      if (ORDERED_VNETS[VN]) begin
        for (int w = BASE; w < BASE + VCS_PER_VNET; w++) begin
          if (w != gv && vc_req[w] && vc_outport[w] == vc_outport[gv] && vc_time[w] < vc_time[gv])
            older = 1'b1;
        end
      end
      el = vc_req[gv] && (vc_has_ovc[gv] ? held_ok : free_ok) && !older;
    end

    assign elig[gv] = el;
  end

  sa_rr_arbiter #(.N(NUM_VCS)) u_vc_arb (
    .clk  (clk),
    .rst_n(rst_n),
    .req  (elig),
    .adv  (adv),
    .any  (win_any),
    .idx  (win_vc)
  );
endmodule

// File: rtl/sa_ovc_state.sv
module sa_ovc_state
  import sa_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int NUM_VCS = 4,
  parameter int CREDITS = 3,
  localparam int VW = idx_w(NUM_VCS),
  localparam int CW = $clog2(CREDITS + 1)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_PORTS-1:0]              take_valid,
  input  logic [NUM_PORTS-1:0][VW-1:0]      take_ovc,
  input  logic [NUM_PORTS-1:0]              take_new,
  input  logic [NUM_PORTS-1:0]              ret_valid,
  input  logic [NUM_PORTS-1:0][VW-1:0]      ret_vc,
  input  logic [NUM_PORTS-1:0]              ret_free,
  output logic [NUM_PORTS-1:0][NUM_VCS-1:0] credit_ok,
  output logic [NUM_PORTS-1:0][NUM_VCS-1:0] ovc_free
);
  for (genvar gp = 0; gp < NUM_PORTS; gp++) begin : g_port
    for (genvar gv = 0; gv < NUM_VCS; gv++) begin : g_ovc
      logic [CW-1:0] cnt;
      logic          busy;
      logic          dec, inc;

      assign dec = take_valid[gp] && (take_ovc[gp] == VW'(gv));
      assign inc = ret_valid[gp] && (ret_vc[gp] == VW'(gv));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt  <= CW'(CREDITS);
          busy <= 1'b0;
        end else begin
          if (dec && !inc)      cnt <= cnt - 1'b1;
          else if (inc && !dec) cnt <= cnt + 1'b1;
          if (dec && take_new[gp])      busy <= 1'b1;
          else if (inc && ret_free[gp]) busy <= 1'b0;
        end
      end

      assign credit_ok[gp][gv] = (cnt != '0);
      assign ovc_free[gp][gv]  = !busy;

      AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) dec |-> cnt != '0); // R7
      AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) (inc && !dec) |-> cnt != CW'(CREDITS)); // R7
      AST_ALLOC_WAS_FREE: assert property (@(posedge clk) disable iff (!rst_n) (dec && take_new[gp]) |-> !busy); // R6
    end
  end
endmodule

// File: rtl/sa_switch_alloc.sv
module sa_switch_alloc
  import sa_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int NUM_VNETS = 2,
  parameter int VCS_PER_VNET = 2,
  parameter int CREDITS = 3,
  parameter int TS_W = 8,
  parameter logic [NUM_VNETS-1:0] ORDERED_VNETS = 2'b10,
  localparam int NUM_VCS = NUM_VNETS * VCS_PER_VNET,
  localparam int TOT = NUM_PORTS * NUM_VCS,
  localparam int PW = idx_w(NUM_PORTS),
  localparam int VW = idx_w(NUM_VCS)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [TOT-1:0]                   req_valid,
  input  logic [TOT-1:0][PW-1:0]           req_outport,
  input  logic [TOT-1:0]                   req_has_ovc,
  input  logic [TOT-1:0][VW-1:0]           req_ovc,
  input  logic [TOT-1:0]                   req_tail,
  input  logic [TOT-1:0][TS_W-1:0]         req_time,
  input  logic [NUM_PORTS-1:0]             dn_credit_valid,
  input  logic [NUM_PORTS-1:0][VW-1:0]     dn_credit_vc,
  input  logic [NUM_PORTS-1:0]             dn_credit_free,
  output logic [NUM_PORTS-1:0]             in_grant,
  output logic [NUM_PORTS-1:0][VW-1:0]     in_grant_vc,
  output logic [NUM_PORTS-1:0][PW-1:0]     in_grant_outport,
  output logic [NUM_PORTS-1:0][VW-1:0]     in_grant_ovc,
  output logic [NUM_PORTS-1:0]             in_grant_new_ovc,
  output logic [NUM_PORTS-1:0]             in_release,
  output logic [NUM_PORTS-1:0]             out_grant,
  output logic [NUM_PORTS-1:0][PW-1:0]     out_grant_inport
);
  logic [NUM_PORTS-1:0]                 s1_any;
  logic [NUM_PORTS-1:0][VW-1:0]         s1_vc;
  logic [NUM_PORTS-1:0][PW-1:0]         s1_op;
  logic [NUM_PORTS-1:0][NUM_PORTS-1:0]  o_req;
  logic [NUM_PORTS-1:0]                 o_any;
  logic [NUM_PORTS-1:0][PW-1:0]         o_idx;
  logic [NUM_PORTS-1:0][NUM_VCS-1:0]    credit_ok;
  logic [NUM_PORTS-1:0][NUM_VCS-1:0]    ovc_free;
  logic [NUM_PORTS-1:0][VW-1:0]         take_ovc;
  logic [NUM_PORTS-1:0]                 take_new;

  // stage one: one VC per input port
  for (genvar gi = 0; gi < NUM_PORTS; gi++) begin : g_in
    sa_input_stage #(
      .NUM_PORTS    (NUM_PORTS),
      .NUM_VNETS    (NUM_VNETS),
      .VCS_PER_VNET (VCS_PER_VNET),
      .TS_W         (TS_W),
      .ORDERED_VNETS(ORDERED_VNETS)
    ) u_in (
      .clk          (clk),
      .rst_n        (rst_n),
      .vc_req       (req_valid[gi*NUM_VCS +: NUM_VCS]),
      .vc_outport   (req_outport[gi*NUM_VCS +: NUM_VCS]),
      .vc_has_ovc   (req_has_ovc[gi*NUM_VCS +: NUM_VCS]),
      .vc_ovc       (req_ovc[gi*NUM_VCS +: NUM_VCS]),
      .vc_time      (req_time[gi*NUM_VCS +: NUM_VCS]),
      .ovc_credit_ok(credit_ok),
      .ovc_free     (ovc_free),
      .adv          (in_grant[gi]),
      .win_any      (s1_any[gi]),
      .win_vc       (s1_vc[gi])
    );
    assign s1_op[gi] = req_outport[gi*NUM_VCS + int'(s1_vc[gi])];
  end

  // stage two: one input port per output port
  for (genvar go = 0; go < NUM_PORTS; go++) begin : g_out
    for (genvar gi = 0; gi < NUM_PORTS; gi++) begin : g_req
      assign o_req[go][gi] = s1_any[gi] && (s1_op[gi] == PW'(go));
    end
    sa_rr_arbiter #(.N(NUM_PORTS)) u_port_arb (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (o_req[go]),
      .adv  (o_any[go]),
      .any  (o_any[go]),
      .idx  (o_idx[go])
    );
  end

  // grants back to the input side, with output-VC choice
  always_comb begin
    int flat, base;
    for (int i = 0; i < NUM_PORTS; i++) begin
      flat = i * NUM_VCS + int'(s1_vc[i]);
      base = (int'(s1_vc[i]) / VCS_PER_VNET) * VCS_PER_VNET;
      in_grant[i] = 1'b0;
      for (int o = 0; o < NUM_PORTS; o++) begin
        if (s1_any[i] && o_any[o] && int'(s1_op[i]) == o && int'(o_idx[o]) == i)
          in_grant[i] = 1'b1;
      end
      in_grant_vc[i]      = s1_vc[i];
      in_grant_outport[i] = s1_op[i];
      in_release[i]       = in_grant[i] && req_tail[flat];
      in_grant_new_ovc[i] = in_grant[i] && !req_has_ovc[flat];
      if (req_has_ovc[flat]) begin
        in_grant_ovc[i] = req_ovc[flat];
      end else begin
        in_grant_ovc[i] = '0;
        for (int k = VCS_PER_VNET - 1; k >= 0; k--) begin
          if (ovc_free[s1_op[i]][base+k] && credit_ok[s1_op[i]][base+k])
            in_grant_ovc[i] = VW'(base + k);
        end
      end
    end
  end

  always_comb begin
    for (int o = 0; o < NUM_PORTS; o++) begin
      take_ovc[o] = in_grant_ovc[o_idx[o]];
      take_new[o] = in_grant_new_ovc[o_idx[o]];
    end
  end

  assign out_grant        = o_any;
  assign out_grant_inport = o_idx;

  sa_ovc_state #(
    .NUM_PORTS(NUM_PORTS),
    .NUM_VCS  (NUM_VCS),
    .CREDITS  (CREDITS)
  ) u_ovc (
    .clk       (clk),
    .rst_n     (rst_n),
    .take_valid(o_any),
    .take_ovc  (take_ovc),
    .take_new  (take_new),
    .ret_valid (dn_credit_valid),
    .ret_vc    (dn_credit_vc),
    .ret_free  (dn_credit_free),
    .credit_ok (credit_ok),
    .ovc_free  (ovc_free)
  );

  AST_GRANT_BALANCE: assert property (@(posedge clk) disable iff (!rst_n) $countones(in_grant) == $countones(out_grant)); // R5

  for (genvar gk = 0; gk < NUM_PORTS; gk++) begin : g_chk
    AST_OUT_MATCHES_IN: assert property (@(posedge clk) disable iff (!rst_n)
      out_grant[gk] |-> (in_grant[out_grant_inport[gk]] && in_grant_outport[out_grant_inport[gk]] == PW'(gk))); // R5
    AST_NEW_OVC_IN_VNET: assert property (@(posedge clk) disable iff (!rst_n)
      in_grant_new_ovc[gk] |-> (int'(in_grant_ovc[gk]) / VCS_PER_VNET) == (int'(in_grant_vc[gk]) / VCS_PER_VNET)); // R6
  end
endmodule

// File: tb/sa_switch_alloc_bench.sv
module sa_switch_alloc_bench;
  localparam int CLK_PERIOD = 10;
  localparam int P = 3;
  localparam int VPV = 2;
  localparam int V = 4;
  localparam int CR = 3;
  localparam int TSW = 8;
  localparam logic [1:0] ORD = 2'b10;
  localparam int T = P * V;
  localparam int PW = 2;
  localparam int VW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [T-1:0]           req_valid;
  logic [T-1:0][PW-1:0]   req_outport;
  logic [T-1:0]           req_has_ovc;
  logic [T-1:0][VW-1:0]   req_ovc;
  logic [T-1:0]           req_tail;
  logic [T-1:0][TSW-1:0]  req_time;
  logic [P-1:0]           dn_credit_valid;
  logic [P-1:0][VW-1:0]   dn_credit_vc;
  logic [P-1:0]           dn_credit_free;
  logic [P-1:0]           in_grant;
  logic [P-1:0][VW-1:0]   in_grant_vc;
  logic [P-1:0][PW-1:0]   in_grant_outport;
  logic [P-1:0][VW-1:0]   in_grant_ovc;
  logic [P-1:0]           in_grant_new_ovc;
  logic [P-1:0]           in_release;
  logic [P-1:0]           out_grant;
  logic [P-1:0][PW-1:0]   out_grant_inport;

  sa_switch_alloc u_sa_switch_alloc (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0;
  int n_fail = 0;
  int m_cred[P][V];
  bit m_busy[P][V];
  int m_iptr[P];
  int m_optr[P];
  int e_w1[P];
  bit e_g[P];
  int e_ovc[P];
  bit e_og[P];
  int e_oin[P];

  task automatic chk(string tag, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic bit elig(int p, int v);
    int idx = p * V + v;
    int op = int'(req_outport[idx]);
    int base = (v / VPV) * VPV;
    bit ok = 0;
    if (!req_valid[idx]) return 0;
    if (req_has_ovc[idx]) ok = m_cred[op][int'(req_ovc[idx])] > 0;
    else for (int k = 0; k < VPV; k++) if (!m_busy[op][base+k] && m_cred[op][base+k] > 0) ok = 1;
    if (ORD[v / VPV])
      for (int w = base; w < base + VPV; w++)
        if (w != v && req_valid[p*V+w] && req_outport[p*V+w] == req_outport[idx] && req_time[p*V+w] < req_time[idx]) ok = 0;
    return ok;
  endfunction

  task automatic model_eval();
    for (int p = 0; p < P; p++) begin
      e_w1[p] = -1;
      e_g[p] = 0;
      for (int k = 0; k < V; k++) begin
        int c = (m_iptr[p] + k) % V;
        if (e_w1[p] < 0 && elig(p, c)) e_w1[p] = c;
      end
    end
    for (int o = 0; o < P; o++) begin
      e_og[o] = 0;
      e_oin[o] = 0;
      for (int k = 0; k < P; k++) begin
        int i = (m_optr[o] + k) % P;
        if (!e_og[o] && e_w1[i] >= 0 && int'(req_outport[i*V+e_w1[i]]) == o) begin
          e_og[o] = 1;
          e_oin[o] = i;
          e_g[i] = 1;
        end
      end
    end
    for (int i = 0; i < P; i++) begin
      e_ovc[i] = 0;
      if (e_g[i]) begin
        int idx = i * V + e_w1[i];
        int op = int'(req_outport[idx]);
        int base = (e_w1[i] / VPV) * VPV;
        if (req_has_ovc[idx]) e_ovc[i] = int'(req_ovc[idx]);
        else for (int k = VPV - 1; k >= 0; k--)
          if (!m_busy[op][base+k] && m_cred[op][base+k] > 0) e_ovc[i] = base + k;
      end
    end
  endtask

  task automatic compare(string tag);
    int ni = 0, no = 0;
    model_eval();
    for (int i = 0; i < P; i++) begin
      chk(tag, "in_grant", int'(in_grant[i]), int'(e_g[i]));
      if (e_g[i] && in_grant[i]) begin
        int idx = i * V + e_w1[i];
        chk({tag, "/R3"}, "in_grant_vc", int'(in_grant_vc[i]), e_w1[i]);
        chk(tag, "in_grant_outport", int'(in_grant_outport[i]), int'(req_outport[idx]));
        chk({tag, "/R6"}, "in_grant_ovc", int'(in_grant_ovc[i]), e_ovc[i]);
        chk({tag, "/R6"}, "in_grant_new_ovc", int'(in_grant_new_ovc[i]), int'(!req_has_ovc[idx]));
        chk({tag, "/R9"}, "in_release", int'(in_release[i]), int'(req_tail[idx]));
      end else begin
        chk({tag, "/R9"}, "in_release idle", int'(in_release[i]), 0);
      end
      ni += int'(in_grant[i]);
    end
    for (int o = 0; o < P; o++) begin
      chk(tag, "out_grant", int'(out_grant[o]), int'(e_og[o]));
      if (e_og[o]) chk({tag, "/R4"}, "out_grant_inport", int'(out_grant_inport[o]), e_oin[o]);
      no += int'(out_grant[o]);
    end
    chk("R5", "grant count balance", ni, no);
  endtask

  task automatic model_update();
    for (int i = 0; i < P; i++) begin
      if (e_g[i]) begin
        int idx = i * V + e_w1[i];
        int op = int'(req_outport[idx]);
        m_cred[op][e_ovc[i]]--;
        if (!req_has_ovc[idx]) m_busy[op][e_ovc[i]] = 1;
        m_iptr[i] = (e_w1[i] + 1) % V;
        m_optr[op] = (i + 1) % P;
      end
    end
    for (int o = 0; o < P; o++) begin
      if (dn_credit_valid[o]) begin
        m_cred[o][int'(dn_credit_vc[o])]++;
        if (dn_credit_free[o]) m_busy[o][int'(dn_credit_vc[o])] = 0;
      end
    end
  endtask

  task automatic idle();
    req_valid = '0; req_outport = '0; req_has_ovc = '0; req_ovc = '0;
    req_tail = '0; req_time = '0;
    dn_credit_valid = '0; dn_credit_vc = '0; dn_credit_free = '0;
  endtask

  task automatic set_req(int p, int v, int op, bit has, int ovc, bit tail, int ts);
    int idx = p * V + v;
    req_valid[idx] = 1'b1;
    req_outport[idx] = PW'(op);
    req_has_ovc[idx] = has;
    req_ovc[idx] = VW'(ovc);
    req_tail[idx] = tail;
    req_time[idx] = TSW'(ts);
  endtask

  task automatic set_dn(int o, int vc, bit fr);
    dn_credit_valid[o] = 1'b1;
    dn_credit_vc[o] = VW'(vc);
    dn_credit_free[o] = fr;
  endtask

  // inputs are set just after a rising edge; outputs sampled at the falling edge
  task automatic step(string tag);
    @(negedge clk);
    compare(tag);
    model_update();
    @(posedge clk);
    #1;
    idle();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int p = 0; p < P; p++) begin
      m_iptr[p] = 0;
      m_optr[p] = 0;
      for (int v = 0; v < V; v++) begin
        m_cred[p][v] = CR;
        m_busy[p][v] = 0;
      end
    end
    idle();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: quiet after reset
    step("R1");
    step("R1");

    // R7 / R2: drain credits of one held output VC, then recover one
    for (int k = 0; k <= CR; k++) begin
      set_req(0, 0, 1, 1, 0, 0, 0);
      step("R7");
    end
    set_req(0, 0, 1, 1, 0, 0, 0);
    set_dn(1, 0, 0);
    step("R2");
    set_req(0, 0, 1, 1, 0, 1, 0);
    step("R7");

    // R6 / R8: allocation of fresh output VCs in vnet 0 at port 2
    set_req(1, 0, 2, 0, 0, 0, 0);
    step("R6");
    set_req(1, 1, 2, 0, 0, 1, 0);
    step("R6");
    set_req(1, 0, 2, 0, 0, 0, 0);
    step("R2");
    set_req(1, 0, 2, 0, 0, 0, 0);
    set_dn(2, 0, 1);
    step("R8");
    set_req(1, 0, 2, 0, 0, 0, 0);
    step("R8");

    // R4: three inputs fight for output 0
    for (int k = 0; k < 6; k++) begin
      for (int i = 0; i < P; i++) set_req(i, 2, 0, 1, i, k[0], 0);
      step("R4");
    end

    // R3: two VCs of port 2 to output 1
    for (int k = 0; k < 4; k++) begin
      set_req(2, 0, 1, 1, 2, 0, 0);
      set_req(2, 1, 1, 1, 3, 0, 0);
      step("R3");
    end

    // R10: ordered vnet 1 at port 0, older VC wins; ties and unordered vnet
    for (int k = 0; k < 2; k++) begin
      set_req(0, 2, 2, 1, 2, 0, 9);
      set_req(0, 3, 2, 1, 3, 0, 4);
      step("R10");
    end
    set_req(0, 2, 2, 1, 2, 0, 5);
    set_req(0, 3, 2, 1, 2, 0, 5);
    step("R10");
    set_req(0, 0, 0, 1, 0, 0, 1);
    set_req(0, 1, 0, 1, 0, 0, 0);
    step("R10");

    // R11: one-cycle request leaves nothing behind
    set_req(2, 3, 0, 1, 3, 1, 0);
    step("R11");
    step("R11");

    // broad sweep against the model
    for (int n = 0; n < 3000; n++) begin
      for (int p = 0; p < P; p++)
        for (int v = 0; v < V; v++)
          if ($urandom_range(9) < 6)
            set_req(p, v, $urandom_range(P - 1), $urandom_range(1), $urandom_range(V - 1),
                    $urandom_range(1), $urandom_range(3));
      for (int o = 0; o < P; o++) begin
        int vc = $urandom_range(V - 1);
        if ($urandom_range(9) < 4 && m_cred[o][vc] < CR)
          set_dn(o, vc, m_busy[o][vc] && ($urandom_range(1) == 1));
      end
      step("R3");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule